// File: doc/BRIEF.md
# Clock-Divider Configuration Register Bank

This block is a byte-wide configuration register bank reached through a simple parallel register bus: an address, write data with a write strobe, and a read strobe with registered read data. It holds a fixed revision code, a 12-bit clock-divider setting, a clock-generator range code, a charge-pump current code, one read/write test byte and two read-only test bytes.

The divider setting is spread over two byte registers and uses a staged commit. A write to the upper divider byte only fills a staging register. The live 12-bit value changes in a single step when the register holding the low nibble is written. The live value then takes the staged byte and the new nibble together. The block drives out the live divider value, the ratio actually used (value plus one), a one-cycle update pulse on each commit, and a flag for settings that give a ratio below two. The range and current codes go straight to the clock generator.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset, divValue is 1693 (0x69D), rangeSel is 2'b01, pumpCode is 3'b001, the read/write test byte is 0x00, and divUpdate, divInvalid and rdData are all 0.
- R2: Address 0x00 reads back the REV_ID parameter (default 0x02). Writes to it have no effect.
- R3: A write to address 0x01 loads only the staged upper divider byte. divValue and divUpdate do not change.
- R4: A write to address 0x02 sets divValue to {staged byte, wrData[7:4]} at the same clock edge that stores the write. wrData[3:0] is discarded.
- R5: divRatio (13 bits) always equals divValue + 1, with no overflow at 0xFFF.
- R6: At address 0x03, bits 7:6 set rangeSel and bits 5:3 set pumpCode. Bits 2:0 read back as zero.
- R7: A read of 0x01 returns the staged byte. A read of 0x02 returns {staged nibble, 4'b0000}. Neither returns the live value.
- R8: Address 0x16 is a read/write test byte. Addresses 0x17 and 0x18 return the TEST_RO_A (default 0xA5) and TEST_RO_B (default 0x5A) parameters, and writes to them have no effect.
- R9: Writes to unmapped addresses change nothing, and reads of them return 0x00.
- R10: divUpdate is high for exactly the one cycle that follows each write to 0x02, and it is low at all other times.
- R11: A divider setting of 0 is stored as written (no clamping), and divInvalid is high exactly while divValue is 0.
- R12: rdData shows the addressed register in the cycle after rdEn is sampled, and 0x00 after a cycle with no read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| divValue | output | 12 | Live committed divider setting |
| divRatio | output | 13 | Operational ratio, divValue + 1 |
| divUpdate | output | 1 | One-cycle pulse on each commit |
| divInvalid | output | 1 | High while divValue is 0 |
| rangeSel | output | 2 | Clock-generator range code |
| pumpCode | output | 3 | Charge-pump current code |

## Verification
The assertions check the following on every cycle:
- divValue stays put across upper-byte writes and across all cycles without a commit.
- A commit carries the written nibble into the live value, and divUpdate pairs exactly with it.
- divRatio and divInvalid track divValue.

Only the bench scenarios can show the readback contents (staged versus live, masked bits, fixed codes, unmapped addresses), read-before-write ordering, and the full 12-bit value assembled from the staging byte. Those scenarios also include the boundary settings 0 and 0xFFF.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int DIV_W  = 12;
  localparam int LO_W   = 4;
  localparam int HI_W   = DIV_W - LO_W;
  localparam int RNG_W  = 2;
  localparam int PMP_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_REV    = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_DIV_HI = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_DIV_LO = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_CLKCTL = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_TEST   = 8'h16;
  localparam logic [ADDR_W-1:0] ADDR_ROA    = 8'h17;
  localparam logic [ADDR_W-1:0] ADDR_ROB    = 8'h18;

  localparam logic [DIV_W-1:0] DIV_RESET   = 12'd1693;
  localparam logic [RNG_W-1:0] RANGE_RESET = 2'b01;
  localparam logic [PMP_W-1:0] PUMP_RESET  = 3'b001;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_REV, SEL_HI, SEL_LO, SEL_CLK, SEL_TEST, SEL_ROA, SEL_ROB
  } rdSel_e;

  typedef struct packed {
    logic   wrStageHi;
    logic   wrCommit;
    logic   wrClkCtl;
    logic   wrTest;
    logic   rdValid;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    strb.rdValid = rdEn;
    if (wrEn) begin
      unique case (addr)
        ADDR_DIV_HI: strb.wrStageHi = 1'b1;
        ADDR_DIV_LO: strb.wrCommit  = 1'b1;
        ADDR_CLKCTL: strb.wrClkCtl  = 1'b1;
        ADDR_TEST:   strb.wrTest    = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      unique case (addr)
        ADDR_REV:    strb.rdSel = SEL_REV;
        ADDR_DIV_HI: strb.rdSel = SEL_HI;
        ADDR_DIV_LO: strb.rdSel = SEL_LO;
        ADDR_CLKCTL: strb.rdSel = SEL_CLK;
        ADDR_TEST:   strb.rdSel = SEL_TEST;
        ADDR_ROA:    strb.rdSel = SEL_ROA;
        ADDR_ROB:    strb.rdSel = SEL_ROB;
        default:     strb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_dpath.sv
module clkcfg_dpath
  import clkcfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID    = 8'h02,
  parameter logic [DATA_W-1:0] TEST_RO_A = 8'hA5,
  parameter logic [DATA_W-1:0] TEST_RO_B = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DIV_W-1:0]  divValue,
  output logic [DIV_W:0]    divRatio,
  output logic              divUpdate,
  output logic              divInvalid,
  output logic [RNG_W-1:0]  rangeSel,
  output logic [PMP_W-1:0]  pumpCode
);
  localparam int CLK_PAD = DATA_W - RNG_W - PMP_W;

  logic [HI_W-1:0]   stageHi;
  logic [LO_W-1:0]   stageLo;
  logic [DIV_W-1:0]  liveDiv;
  logic [DATA_W-1:0] testReg;
  logic [DATA_W-1:0] rdMux;
  logic              updPulse;

  // staging and commit of the divider setting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageHi  <= DIV_RESET[DIV_W-1:LO_W];
      stageLo  <= DIV_RESET[LO_W-1:0];
      liveDiv  <= DIV_RESET;
      updPulse <= 1'b0;
    end else begin
      updPulse <= strb.wrCommit;
      if (strb.wrStageHi) stageHi <= wrData;
      if (strb.wrCommit) begin
        stageLo <= wrData[DATA_W-1 -: LO_W];
        liveDiv <= {stageHi, wrData[DATA_W-1 -: LO_W]};
      end
    end
  end

  // clock-generator control and test byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeSel <= RANGE_RESET;
      pumpCode <= PUMP_RESET;
      testReg  <= '0;
    end else begin
      if (strb.wrClkCtl) begin
        rangeSel <= wrData[DATA_W-1 -: RNG_W];
        pumpCode <= wrData[DATA_W-RNG_W-1 -: PMP_W];
      end
      if (strb.wrTest) testReg <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_REV:  rdMux = REV_ID;
      SEL_HI:   rdMux = stageHi;
      SEL_LO:   rdMux = {stageLo, {(DATA_W-LO_W){1'b0}}};
      SEL_CLK:  rdMux = {rangeSel, pumpCode, {CLK_PAD{1'b0}}};
      SEL_TEST: rdMux = testReg;
      SEL_ROA:  rdMux = TEST_RO_A;
      SEL_ROB:  rdMux = TEST_RO_B;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdValid ? rdMux : '0;
  end

  assign divValue   = liveDiv;
  assign divRatio   = {1'b0, liveDiv} + {{DIV_W{1'b0}}, 1'b1};
  assign divUpdate  = updPulse;
  assign divInvalid = (liveDiv == '0);
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] REV_ID    = 8'h02,
  parameter logic [7:0] TEST_RO_A = 8'hA5,
  parameter logic [7:0] TEST_RO_B = 8'h5A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  output logic [7:0]  rdData,
  output logic [11:0] divValue,
  output logic [12:0] divRatio,
  output logic        divUpdate,
  output logic        divInvalid,
  output logic [1:0]  rangeSel,
  output logic [2:0]  pumpCode
);
  strobes_t strb;

  clkcfg_ctrl uCtrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  clkcfg_dpath #(
    .REV_ID    (REV_ID),
    .TEST_RO_A (TEST_RO_A),
    .TEST_RO_B (TEST_RO_B)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .rdData     (rdData),
    .divValue   (divValue),
    .divRatio   (divRatio),
    .divUpdate  (divUpdate),
    .divInvalid (divInvalid),
    .rangeSel   (rangeSel),
    .pumpCode   (pumpCode)
  );
endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  addr,
  input logic [7:0]  wrData,
  input logic        wrEn,
  input logic [11:0] divValue,
  input logic [12:0] divRatio,
  input logic        divUpdate,
  input logic        divInvalid
);
  logic hiWr, loWr;
  assign hiWr = wrEn && (addr == 8'h01);
  assign loWr = wrEn && (addr == 8'h02);

  a_r3_stage_keeps_live: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> $stable(divValue));

  a_r4_commit_nibble: assert property (@(posedge clk) disable iff (!rstN)
    loWr |=> (divValue[3:0] == $past(wrData[7:4])));

  a_r4_live_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !loWr |=> $stable(divValue));

  a_r5_ratio_tracks: assert property (@(posedge clk) disable iff (!rstN)
    divRatio == ({1'b0, divValue} + 13'd1));

  a_r10_pulse_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    loWr |=> divUpdate);

  a_r10_pulse_only_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    !loWr |=> !divUpdate);

  a_r11_invalid_flag: assert property (@(posedge clk) disable iff (!rstN)
    divInvalid == (divValue == 12'd0));
endmodule

bind clkcfg_regbank clkcfg_regbank_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .divValue   (divValue),
  .divRatio   (divRatio),
  .divUpdate  (divUpdate),
  .divInvalid (divInvalid)
);

// File: tb/clkcfg_regbank_test.sv
module clkcfg_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [11:0] divValue;
  logic [12:0] divRatio;
  logic        divUpdate, divInvalid;
  logic [1:0]  rangeSel;
  logic [2:0]  pumpCode;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  clkcfg_regbank uut (.*);

  // {isRead, addr, data-or-expected}
  localparam int NVEC = 16;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h02},  // R2 revision
    {1'b0, 8'h00, 8'hFF},  // R2 write ignored
    {1'b1, 8'h00, 8'h02},
    {1'b1, 8'h01, 8'h69},  // R7 staged byte
    {1'b1, 8'h02, 8'hD0},  // R7 staged nibble
    {1'b1, 8'h03, 8'h48},  // R6 reset clock control
    {1'b0, 8'h03, 8'hB7},
    {1'b1, 8'h03, 8'hB0},  // R6 low bits masked
    {1'b0, 8'h16, 8'h3C},
    {1'b1, 8'h16, 8'h3C},  // R8 rw test
    {1'b0, 8'h17, 8'h11},
    {1'b1, 8'h17, 8'hA5},  // R8 ro test A
    {1'b0, 8'h18, 8'h22},
    {1'b1, 8'h18, 8'h5A},  // R8 ro test B
    {1'b0, 8'h40, 8'h77},
    {1'b1, 8'h40, 8'h00}   // R9 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    d = rdData;
    rdEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 divValue", divValue, 12'h69D);
    check("R1 rangeSel", rangeSel, 2'b01);
    check("R1 pumpCode", pumpCode, 3'b001);
    check("R1 divUpdate", divUpdate, 0);
    check("R1 divInvalid", divInvalid, 0);
    check("R1 rdData", rdData, 0);
    check("R5 reset ratio", divRatio, 13'h69E);
    doRead(8'h16, rd);
    check("R1 test byte", rd, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][16]) begin
        doRead(VEC[i][15:8], rd);
        check($sformatf("vector %0d read", i), rd, VEC[i][7:0]);
      end else begin
        doWrite(VEC[i][15:8], VEC[i][7:0]);
      end
    end
    check("R6 rangeSel", rangeSel, 2'b10);
    check("R6 pumpCode", pumpCode, 3'b110);
    check("R9 divValue untouched", divValue, 12'h69D);

    // R12 idle read data returns to zero
    @(negedge clk);
    check("R12 idle rdData", rdData, 0);

    // R3 staging write does not change live value
    doWrite(8'h01, 8'h12);
    check("R3 live held", divValue, 12'h69D);
    check("R3 no pulse", divUpdate, 0);
    doRead(8'h01, rd);
    check("R7 staged readback", rd, 8'h12);

    // R4 commit
    doWrite(8'h02, 8'h3F);
    check("R4 commit value", divValue, 12'h123);
    check("R10 pulse high", divUpdate, 1);
    check("R5 ratio", divRatio, 13'h124);
    @(negedge clk);
    check("R10 pulse one cycle", divUpdate, 0);
    doRead(8'h02, rd);
    check("R4 low bits dropped", rd, 8'h30);

    // R12 read concurrent with write returns old value
    @(negedge clk);
    addr = 8'h01; wrData = 8'hAB; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R12 read before write", rdData, 8'h12);
    doRead(8'h01, rd);
    check("R12 write landed", rd, 8'hAB);
    check("R3 live still held", divValue, 12'h123);

    // R11 zero setting
    doWrite(8'h01, 8'h00);
    doWrite(8'h02, 8'h00);
    check("R11 zero stored", divValue, 12'h000);
    check("R11 invalid flag", divInvalid, 1);
    check("R5 ratio at zero", divRatio, 13'h001);

    // R5 top value, no overflow
    doWrite(8'h01, 8'hFF);
    check("R11 still invalid before commit", divInvalid, 1);
    doWrite(8'h02, 8'hF0);
    check("R4 max value", divValue, 12'hFFF);
    check("R5 ratio at max", divRatio, 13'h1000);
    check("R11 flag cleared", divInvalid, 0);

    // R4 second commit reuses staged byte
    doWrite(8'h02, 8'h50);
    check("R4 staged reuse", divValue, 12'hFF5);
    check("R10 second pulse", divUpdate, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule